// File: doc/BRIEF.md
# Masked Identifier Channel Matcher

This block decides which of a set of reception channels takes an incoming frame header and where the frame's data buffer sits in data RAM. Each channel holds an identifier tag, a per-bit comparison mask, a set of command bits, an enable bit, a spy bit, a buffer offset and a buffer length. These are kept in a small register file that a host reads and writes one 12-bit field at a time.

When a header is presented, every active channel compares the 12-bit identifier and the extended-format bit against its own settings. The lowest-numbered channel that matches wins. One cycle later the block reports several results: the winner, whether an acknowledge should be driven, and the buffer address. It also writes back the identifier that actually arrived into the winner's tag, and emits the first buffer byte, which carries the received command bits.

A channel whose buffer length is zero does not own a buffer. Its offset names another channel, one level deep, whose offset and length are used instead. The matching context stays with the original channel.

Top module: `id_chan_matcher`

## Requirements
- R1: A channel matches only when every identifier bit whose mask bit is 1 equals the corresponding tag bit. Mask bits at 0 are don't-care.
- R2: Of the received command nibble {EXT,RAK,RNW,RTR} (bits 3..0), only EXT (bit 3) is compared, against the channel's configured EXT. RAK, RNW and RTR never affect matching.
- R3: A channel can hit only while its enable bit (ctrl bit 5) is 1 and its configured RTR bit (ctrl bit 0) is 0. Otherwise it is inactive.
- R4: When several channels match, the lowest-numbered one wins. When none match, res_hit is 0, res_chan is 0 and nothing is written.
- R5: On a hit, the winner's tag is overwritten with the received identifier. If a host write to that same channel's tag lands in the same cycle, the write-back wins. A host write to any other field or channel in that cycle still takes effect.
- R6: On a hit with a valid buffer, buf_we is 1 and buf_wdata is {5'b0, RAK, RNW, RTR}, to be stored at res_addr.
- R7: The buffer address is 0x80 plus the 7-bit buffer offset. If the winner's length field is 0, its offset is taken as a channel number, and that channel's offset (and length) give the address; res_linked is then 1.
- R8: A link whose value is not below the channel count, whose top three bits are not zero, or which names another zero-length channel raises res_link_err. In that case res_addr_valid and buf_we stay 0.
- R9: res_ack is 1 only when there is a hit, the received RAK is 1 and the winner's spy bit (ctrl bit 4) is 0.
- R10: All results are registered. They appear in the cycle after hdr_valid is sampled, and res_valid is 0 in every cycle that follows no header.
- R11: After reset, all channel fields read 0 (so no channel is active) and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Host field write strobe |
| cfg_ch | input | 4 | Channel selected for host access |
| cfg_sel | input | 2 | Field: 0 tag, 1 mask, 2 ctrl, 3 buffer {len[11:7], offset[6:0]} |
| cfg_wdata | input | 12 | Host write data |
| cfg_rdata | output | 12 | Selected field, combinational read |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_id | input | 12 | Received identifier |
| hdr_cmd | input | 4 | Received {EXT,RAK,RNW,RTR} |
| res_valid | output | 1 | Result for last cycle's header |
| res_hit | output | 1 | Some channel matched |
| res_chan | output | 4 | Winning channel |
| res_ack | output | 1 | Drive acknowledge |
| res_linked | output | 1 | Buffer came through a link |
| res_link_err | output | 1 | Link invalid |
| res_addr_valid | output | 1 | res_addr is usable |
| res_addr | output | 8 | Buffer address in data RAM |
| buf_we | output | 1 | Write first buffer byte |
| buf_wdata | output | 8 | First buffer byte |

## Verification
The tag write-back from a hit and a host write to the register file can land on the same clock edge. Both orderings are provoked. In one, the host writes the winning channel's tag in the very cycle its header is sampled. In the other, the host writes a different channel's tag during a hit. Afterwards the tags are read back through cfg_rdata. The first must show the received identifier, with the host value lost. The second must show both updates.

// File: rtl/chm_pkg.sv
// Package: shared widths, control bit positions and field selects for the
// identifier channel matcher. Assumes 12-bit identifiers and 7-bit offsets.
package chm_pkg;
    parameter int ID_W   = 12;
    parameter int CMD_W  = 4;
    parameter int PTR_W  = 7;
    parameter int LEN_W  = 5;
    parameter int ADDR_W = 8;
    parameter int CTRL_W = 6;

    // command nibble positions (received and configured)
    localparam int C_RTR = 0;
    localparam int C_RNW = 1;
    localparam int C_RAK = 2;
    localparam int C_EXT = 3;
    localparam int C_SPY = 4;
    localparam int C_EN  = 5;

    typedef enum logic [1:0] {
        FLD_TAG  = 2'd0,
        FLD_MASK = 2'd1,
        FLD_CTRL = 2'd2,
        FLD_BUF  = 2'd3
    } field_e;

    typedef struct packed {
        logic [ID_W-1:0]   tag;
        logic [ID_W-1:0]   mask;
        logic [CTRL_W-1:0] ctrl;
        logic [PTR_W-1:0]  ptr;
        logic [LEN_W-1:0]  len;
    } chan_cfg_t;
endpackage

// File: rtl/chm_regfile.sv
// Channel register file. Holds per-channel settings, serves host field
// writes and a combinational read, and applies the identifier write-back
// after a hit. Assumes one host write per cycle; write-back beats the host
// on the same tag.
module chm_regfile
    import chm_pkg::*;
#(
    parameter int NUM_CH = 14,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CH_W-1:0] cfg_ch,
    input  logic [1:0]      cfg_sel,
    input  logic [ID_W-1:0] cfg_wdata,
    output logic [ID_W-1:0] cfg_rdata,
    input  logic            wb_en,
    input  logic [CH_W-1:0] wb_ch,
    input  logic [ID_W-1:0] wb_id,
    output chan_cfg_t       cfg [NUM_CH]
);
    chan_cfg_t regs_q [NUM_CH];

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            // Per-channel storage: host write first, then write-back override.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs_q[i] <= '0;
                end else begin
                    if (cfg_we && cfg_ch == CH_W'(i)) begin
                        case (field_e'(cfg_sel))
                            FLD_TAG:  regs_q[i].tag  <= cfg_wdata;
                            FLD_MASK: regs_q[i].mask <= cfg_wdata;
                            FLD_CTRL: regs_q[i].ctrl <= cfg_wdata[CTRL_W-1:0];
                            default: begin
                                regs_q[i].ptr <= cfg_wdata[PTR_W-1:0];
                                regs_q[i].len <= cfg_wdata[PTR_W +: LEN_W];
                            end
                        endcase
                    end
                    if (wb_en && wb_ch == CH_W'(i))
                        regs_q[i].tag <= wb_id;
                end
            end
            assign cfg[i] = regs_q[i];
        end
    endgenerate

    // Host read mux; out-of-range channels read zero.
    always_comb begin
        cfg_rdata = '0;
        if (int'(cfg_ch) < NUM_CH) begin
            case (field_e'(cfg_sel))
                FLD_TAG:  cfg_rdata = regs_q[cfg_ch].tag;
                FLD_MASK: cfg_rdata = regs_q[cfg_ch].mask;
                FLD_CTRL: cfg_rdata = ID_W'(regs_q[cfg_ch].ctrl);
                default:  cfg_rdata = ID_W'({regs_q[cfg_ch].len, regs_q[cfg_ch].ptr});
            endcase
        end
    end

    // R5: a write-back always leaves the received identifier in the tag.
    assert_tag_writeback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> regs_q[$past(wb_ch)].tag == $past(wb_id));
endmodule

// File: rtl/chm_compare.sv
// Per-channel comparator. Produces one hit bit per channel from the masked
// identifier comparison, the EXT bit and the channel's activity state.
// Assumes mask bit 1 means "compare".
module chm_compare
    import chm_pkg::*;
#(
    parameter int NUM_CH = 14
) (
    input  chan_cfg_t        cfg [NUM_CH],
    input  logic [ID_W-1:0]  id,
    input  logic [CMD_W-1:0] cmd,
    output logic [NUM_CH-1:0] hit_vec
);
    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
            logic active;
            logic id_ok;
            logic ext_ok;
            // Activity: enabled and not configured as a reply request.
            assign active = cfg[i].ctrl[C_EN] && !cfg[i].ctrl[C_RTR];
            // Masked identifier equality.
            assign id_ok  = ((id ^ cfg[i].tag) & cfg[i].mask) == '0;
            // Only EXT is compared among the command bits.
            assign ext_ok = cmd[C_EXT] == cfg[i].ctrl[C_EXT];
            assign hit_vec[i] = active && id_ok && ext_ok;
        end
    endgenerate
endmodule

// File: rtl/chm_prio.sv
// Lowest-index priority picker over the hit vector. Assumes idx is only
// meaningful while any is high; it reads zero otherwise.
module chm_prio #(
    parameter int NUM_CH = 14,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit_vec,
    output logic              any,
    output logic [CH_W-1:0]   idx
);
    // Scan from the top so the lowest hit is the last assignment.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any = 1'b1;
                idx = CH_W'(i);
            end
        end
    end

    // R4: winner really hit and no lower channel hit.
    assert_winner_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (hit_vec[idx] && ((hit_vec & ((NUM_CH'(1) << idx) - NUM_CH'(1))) == '0)));
    assert_nohit_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !any |-> (idx == '0 && hit_vec == '0));
endmodule

// File: rtl/chm_resolve.sv
// Buffer resolver. Turns the winning channel's offset and length into a data
// RAM address, following one level of link for zero-length channels. Assumes
// the caller qualifies the result with a hit.
module chm_resolve
    import chm_pkg::*;
#(
    parameter int NUM_CH            = 14,
    parameter logic [ADDR_W-1:0] RAM_BASE = 8'h80,
    localparam int CH_W             = $clog2(NUM_CH)
) (
    input  chan_cfg_t         cfg [NUM_CH],
    input  logic [CH_W-1:0]   sel,
    output logic              linked,
    output logic              link_err,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr
);
    chan_cfg_t       own;
    chan_cfg_t       tgt;
    logic [PTR_W-1:0] link_no;
    logic            in_range;
    logic [PTR_W-1:0] eff_ptr;

    // Fetch the winner and decode its offset as a possible link.
    always_comb begin
        own      = cfg[sel];
        link_no  = own.ptr;
        in_range = (link_no[PTR_W-1:PTR_W-3] == 3'b000) && (int'(link_no) < NUM_CH);
        tgt      = in_range ? cfg[link_no[CH_W-1:0]] : '0;
    end

    // Pick the effective offset and judge link validity.
    always_comb begin
        linked   = (own.len == '0);
        link_err = linked && (!in_range || tgt.len == '0);
        eff_ptr  = linked ? tgt.ptr : own.ptr;
        addr_valid = !link_err;
        addr     = addr_valid ? (RAM_BASE + ADDR_W'(eff_ptr)) : '0;
    end
endmodule

// File: rtl/id_chan_matcher.sv
// Top: masked identifier channel matcher. Compares each header against all
// channels, picks the lowest hit, resolves its buffer and registers the
// results one cycle after the header. Assumes at most one header per cycle.
module id_chan_matcher
    import chm_pkg::*;
#(
    parameter int NUM_CH = 14,
    parameter logic [ADDR_W-1:0] RAM_BASE = 8'h80,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [1:0]        cfg_sel,
    input  logic [ID_W-1:0]   cfg_wdata,
    output logic [ID_W-1:0]   cfg_rdata,
    input  logic              hdr_valid,
    input  logic [ID_W-1:0]   hdr_id,
    input  logic [CMD_W-1:0]  hdr_cmd,
    output logic              res_valid,
    output logic              res_hit,
    output logic [CH_W-1:0]   res_chan,
    output logic              res_ack,
    output logic              res_linked,
    output logic              res_link_err,
    output logic              res_addr_valid,
    output logic [ADDR_W-1:0] res_addr,
    output logic              buf_we,
    output logic [7:0]        buf_wdata
);
    chan_cfg_t         cfg [NUM_CH];
    logic [NUM_CH-1:0] hit_vec;
    logic              any;
    logic [CH_W-1:0]   win;
    logic              lk, lk_err, a_ok;
    logic [ADDR_W-1:0] addr;
    logic              hit_now;

    assign hit_now = hdr_valid && any;

    chm_regfile #(.NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .wb_en(hit_now), .wb_ch(win), .wb_id(hdr_id),
        .cfg(cfg)
    );

    chm_compare #(.NUM_CH(NUM_CH)) u_cmp (
        .cfg(cfg), .id(hdr_id), .cmd(hdr_cmd), .hit_vec(hit_vec)
    );

    chm_prio #(.NUM_CH(NUM_CH)) u_prio (
        .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .any(any), .idx(win)
    );

    chm_resolve #(.NUM_CH(NUM_CH), .RAM_BASE(RAM_BASE)) u_res (
        .cfg(cfg), .sel(win), .linked(lk), .link_err(lk_err),
        .addr_valid(a_ok), .addr(addr)
    );

    // Result register: every output is qualified by a sampled hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid      <= 1'b0;
            res_hit        <= 1'b0;
            res_chan       <= '0;
            res_ack        <= 1'b0;
            res_linked     <= 1'b0;
            res_link_err   <= 1'b0;
            res_addr_valid <= 1'b0;
            res_addr       <= '0;
            buf_we         <= 1'b0;
            buf_wdata      <= '0;
        end else begin
            res_valid      <= hdr_valid;
            res_hit        <= hit_now;
            res_chan       <= hit_now ? win : '0;
            res_ack        <= hit_now && hdr_cmd[C_RAK] && !cfg[win].ctrl[C_SPY];
            res_linked     <= hit_now && lk;
            res_link_err   <= hit_now && lk_err;
            res_addr_valid <= hit_now && a_ok;
            res_addr       <= (hit_now && a_ok) ? addr : '0;
            buf_we         <= hit_now && a_ok;
            buf_wdata      <= hit_now ? {5'b0, hdr_cmd[C_RAK], hdr_cmd[C_RNW], hdr_cmd[C_RTR]} : '0;
        end
    end

    // R10: results only follow a sampled header.
    assert_valid_follows_hdr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !res_valid && !res_hit && !buf_we);
    // R9: acknowledge needs a hit with RAK set.
    assert_ack_needs_rak_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_ack |-> res_hit && $past(hdr_cmd[C_RAK]));
    // R8: a bad link never yields an address or a buffer write.
    assert_linkerr_noaddr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_link_err |-> !res_addr_valid && !buf_we && res_linked);
    // R7: addresses always land at or above the data RAM base.
    assert_addr_in_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_addr_valid |-> res_addr >= RAM_BASE);
    // R6: the byte write carries RAK/RNW/RTR of the sampled header.
    assert_byte_content_R6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> buf_wdata == {5'b0, $past(hdr_cmd[2:0])});
endmodule

// File: tb/sim_id_chan_matcher.sv
module sim_id_chan_matcher;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        cfg_we = 0;
    logic [3:0]  cfg_ch = 0;
    logic [1:0]  cfg_sel = 0;
    logic [11:0] cfg_wdata = 0;
    logic [11:0] cfg_rdata;
    logic        hdr_valid = 0;
    logic [11:0] hdr_id = 0;
    logic [3:0]  hdr_cmd = 0;
    logic        res_valid, res_hit, res_ack, res_linked, res_link_err, res_addr_valid, buf_we;
    logic [3:0]  res_chan;
    logic [7:0]  res_addr, buf_wdata;

    int checks = 0;
    int fails  = 0;

    id_chan_matcher u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .hdr_valid(hdr_valid), .hdr_id(hdr_id), .hdr_cmd(hdr_cmd),
        .res_valid(res_valid), .res_hit(res_hit), .res_chan(res_chan),
        .res_ack(res_ack), .res_linked(res_linked), .res_link_err(res_link_err),
        .res_addr_valid(res_addr_valid), .res_addr(res_addr),
        .buf_we(buf_we), .buf_wdata(buf_wdata)
    );

    typedef struct packed {
        logic [11:0] id;
        logic [3:0]  cmd;
        logic        hit;
        logic [3:0]  chan;
        logic        ack;
        logic        lnk;
        logic        lerr;
        logic        av;
        logic [7:0]  addr;
        logic [7:0]  wd;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{12'h123, 4'b0100, 1, 4'd0, 1, 0, 0, 1, 8'h90, 8'h04},  // R1 R4 R9: ch0 beats ch1
        '{12'h125, 4'b0000, 1, 4'd1, 0, 0, 0, 1, 8'hA0, 8'h00},  // R1 mask don't-care
        '{12'h123, 4'b1000, 0, 4'd0, 0, 0, 0, 0, 8'h00, 8'h00},  // R2 EXT mismatch
        '{12'h300, 4'b1100, 1, 4'd2, 0, 0, 0, 1, 8'hB0, 8'h04},  // R9 spy drops ack
        '{12'h400, 4'b0100, 0, 4'd0, 0, 0, 0, 0, 8'h00, 8'h00},  // R3 disabled
        '{12'h500, 4'b0100, 0, 4'd0, 0, 0, 0, 0, 8'h00, 8'h00},  // R3 RTR config
        '{12'h600, 4'b0110, 1, 4'd5, 1, 1, 0, 1, 8'hC0, 8'h06},  // R7 link to ch6
        '{12'h700, 4'b0100, 1, 4'd7, 1, 1, 1, 0, 8'h00, 8'h04},  // R8 link out of range
        '{12'h800, 4'b0000, 1, 4'd8, 0, 1, 1, 0, 8'h00, 8'h00},  // R8 link to zero length
        '{12'h12F, 4'b0011, 1, 4'd1, 0, 0, 0, 1, 8'hA0, 8'h03}   // R2 R6 RNW/RTR ignored
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [3:0] ch, input logic [1:0] sel, input logic [11:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic host_rd(input logic [3:0] ch, input logic [1:0] sel, output logic [11:0] d);
        @(negedge clk);
        cfg_ch = ch; cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    // ctrl: [5]en [4]spy [3]EXT [2]RAK [1]RNW [0]RTR; buf: {len,ptr}
    task automatic setup();
        host_wr(0, 0, 12'h123); host_wr(0, 1, 12'hFFF); host_wr(0, 2, 12'h020); host_wr(0, 3, {5'd4, 7'h10});
        host_wr(1, 0, 12'h120); host_wr(1, 1, 12'hFF0); host_wr(1, 2, 12'h020); host_wr(1, 3, {5'd8, 7'h20});
        host_wr(2, 0, 12'h300); host_wr(2, 1, 12'hFFF); host_wr(2, 2, 12'h038); host_wr(2, 3, {5'd2, 7'h30});
        host_wr(3, 0, 12'h400); host_wr(3, 1, 12'hFFF); host_wr(3, 2, 12'h000); host_wr(3, 3, {5'd2, 7'h08});
        host_wr(4, 0, 12'h500); host_wr(4, 1, 12'hFFF); host_wr(4, 2, 12'h021); host_wr(4, 3, {5'd2, 7'h08});
        host_wr(5, 0, 12'h600); host_wr(5, 1, 12'hFFF); host_wr(5, 2, 12'h020); host_wr(5, 3, {5'd0, 7'd6});
        host_wr(6, 0, 12'hFFF); host_wr(6, 1, 12'hFFF); host_wr(6, 2, 12'h000); host_wr(6, 3, {5'd3, 7'h40});
        host_wr(7, 0, 12'h700); host_wr(7, 1, 12'hFFF); host_wr(7, 2, 12'h020); host_wr(7, 3, {5'd0, 7'd20});
        host_wr(8, 0, 12'h800); host_wr(8, 1, 12'hFFF); host_wr(8, 2, 12'h020); host_wr(8, 3, {5'd0, 7'd9});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [11:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R11: reset state
        chk("R11 res_valid", res_valid, 0);
        chk("R11 res_addr", res_addr, 0);
        host_rd(0, 2, rd); chk("R11 ctrl reads 0", rd, 0);
        host_rd(5, 0, rd); chk("R11 tag reads 0", rd, 0);
        // R11/R3: no channel hits out of reset
        @(negedge clk); hdr_valid = 1; hdr_id = 12'h000; hdr_cmd = 4'b0100;
        @(negedge clk); hdr_valid = 0;
        chk("R11 no hit after reset", {res_valid, res_hit, buf_we}, 3'b100);

        setup();

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            hdr_valid = 1; hdr_id = VECS[v].id; hdr_cmd = VECS[v].cmd;
            @(negedge clk);
            hdr_valid = 0;
            chk($sformatf("R10 v%0d valid", v), res_valid, 1);
            chk($sformatf("R1 R4 v%0d hit", v), res_hit, VECS[v].hit);
            chk($sformatf("R4 v%0d chan", v), res_chan, VECS[v].chan);
            chk($sformatf("R9 v%0d ack", v), res_ack, VECS[v].ack);
            chk($sformatf("R7 v%0d linked", v), res_linked, VECS[v].lnk);
            chk($sformatf("R8 v%0d link_err", v), res_link_err, VECS[v].lerr);
            chk($sformatf("R7 v%0d addr_valid", v), res_addr_valid, VECS[v].av);
            chk($sformatf("R7 v%0d addr", v), res_addr, VECS[v].addr);
            chk($sformatf("R6 v%0d buf_we", v), buf_we, VECS[v].hit & VECS[v].av);
            chk($sformatf("R6 v%0d wdata", v), buf_wdata, VECS[v].wd);
        end

        // R10: idle cycle yields no result
        @(negedge clk);
        chk("R10 idle res_valid", {res_valid, res_hit, buf_we}, 0);

        // R5: write-back of masked bits into ch1 (last hit 0x12F)
        host_rd(1, 0, rd); chk("R5 ch1 tag after hit", rd, 12'h12F);
        host_rd(0, 0, rd); chk("R5 ch0 tag unchanged", rd, 12'h123);

        // R5: host writes ch1 tag in the same cycle as a ch1 hit
        @(negedge clk);
        hdr_valid = 1; hdr_id = 12'h12A; hdr_cmd = 4'b0000;
        cfg_we = 1; cfg_ch = 1; cfg_sel = 0; cfg_wdata = 12'h7AB;
        @(negedge clk);
        hdr_valid = 0; cfg_we = 0;
        chk("R5 collide hit chan", res_chan, 1);
        host_rd(1, 0, rd); chk("R5 write-back wins", rd, 12'h12A);

        // R5: host writes ch3 tag while ch0 hits; both land
        @(negedge clk);
        hdr_valid = 1; hdr_id = 12'h123; hdr_cmd = 4'b0000;
        cfg_we = 1; cfg_ch = 3; cfg_sel = 0; cfg_wdata = 12'h4AA;
        @(negedge clk);
        hdr_valid = 0; cfg_we = 0;
        chk("R5 other hit chan", res_chan, 0);
        host_rd(3, 0, rd); chk("R5 other host write lands", rd, 12'h4AA);
        host_rd(0, 0, rd); chk("R5 ch0 tag after hit", rd, 12'h123);

        // R3: enabling ch3 makes it hit; RTR-configured ch4 stays dead
        host_wr(3, 2, 12'h020);
        @(negedge clk); hdr_valid = 1; hdr_id = 12'h4AA; hdr_cmd = 4'b0100;
        @(negedge clk); hdr_valid = 0;
        chk("R3 enabled ch3 hits", {res_hit, res_chan}, {1'b1, 4'd3});
        chk("R7 ch3 addr", res_addr, 8'h88);

        // R8: link with high bits set (0x46) on ch5
        host_wr(5, 3, {5'd0, 7'h46});
        @(negedge clk); hdr_valid = 1; hdr_id = 12'h600; hdr_cmd = 4'b0000;
        @(negedge clk); hdr_valid = 0;
        chk("R8 high-bit link err", {res_link_err, res_addr_valid, buf_we}, 3'b100);

        // R11: reset mid-run clears fields
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        host_rd(2, 3, rd); chk("R11 buf field cleared", rd, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule